// File: doc/BRIEF.md
# Stack Bytecode Execution Engine

This block runs a small set of one-byte stack opcodes that it reads one byte at a time from a code memory. Its program counter drives the code address, and the byte at that address comes back on the same cycle. Operands sit in a 16-entry hardware stack built as a chain of shift registers. A push moves every entry one place deeper. A pop moves every entry one place back toward the top. Operations can see only the top entry and the one below it.

Two small register arrays hold the method's local variables and its constant pool. Both are written through a load port while the run input `go` is low. The engine starts at address 0 after reset and moves forward while `go` is high. It stops in one of two ways. A return opcode raises `halted` and publishes the top value on `ret_val`. A stack overflow, a stack underflow, an unknown opcode or an out-of-range index raises the sticky `fault` flag.

Top module: `bce_engine`

## Requirements
- R1: After reset, `pc` is 0, the stack is empty, `tos` is 0, `halted` and `fault` are low, `ret_val` is 0, and every local and pool entry is 0.
- R2: Opcode 0x10 pushes its single argument byte, sign-extended to 32 bits. Opcode 0x57 pops one entry, which brings the previous top back onto `tos`.
- R3: Opcode 0x59 pushes a copy of the top entry. Opcode 0x60 pops the two top entries and pushes their 32-bit sum, wrapping on overflow.
- R4: Opcode 0xA7 reads a signed 16-bit offset, high byte first, and sets `pc` to the address of the 0xA7 byte plus that offset. Both forward and backward jumps are supported.
- R5: Opcode 0x84 reads a local index byte and then a constant byte, and adds the sign-extended constant to that local. Opcode 0x15 reads a local index byte and pushes that local.
- R6: Opcode 0x13 reads a 16-bit pool index, high byte first, and pushes that constant-pool entry.
- R7: Opcode 0xAC with a non-empty stack raises `halted` and drives the top entry onto `ret_val`. After that, `pc`, `tos` and `ret_val` stay fixed until reset, whatever `go` does.
- R8: These cases raise `fault`: a push with 16 entries already on the stack, 0x57 or 0xAC on an empty stack, and 0x60 with fewer than two entries. The stack does not change. `pc` stays on the byte being decoded, and `fault` stays high until reset.
- R9: Any opcode outside the set 0x10, 0x13, 0x15, 0x57, 0x59, 0x60, 0x84, 0xA7, 0xAC raises `fault`. So does a local index of 8 or more, or a pool index of 8 or more.
- R10: While `go` is low, the engine does not move: `pc` and the stack hold. The load port writes entry `ld_addr` of the pool (`ld_pool`=1) or of the locals (`ld_pool`=0) only while `go` is low. A write made while `go` is high is ignored.
- R11: The engine takes one code byte per cycle while `go` is high, so an instruction with n argument bytes finishes n+1 cycles after its opcode is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| go | input | 1 | Run enable; the engine steps only while high |
| ld_we | input | 1 | Load-port write strobe |
| ld_pool | input | 1 | Load-port bank select: 1 selects the pool, 0 selects the locals |
| ld_addr | input | 8 | Load-port entry index |
| ld_data | input | 32 | Load-port write data |
| code_byte | input | 8 | Code byte at address `pc`, valid in the same cycle |
| pc | output | 16 | Program counter and code memory address |
| tos | output | 32 | Current top of stack (0 when empty) |
| halted | output | 1 | Return executed |
| fault | output | 1 | Sticky error stop |
| ret_val | output | 32 | Value returned by 0xAC |

## Verification
The bench goes after the edges of the shift chain. It pushes exactly one entry past full and checks that the top stays the same and `pc` freezes. A design that tested for full one entry late would silently drop the deepest value instead of stopping. It also tries adds and returns on stacks that are too shallow, where a missing check would sum or return a zero that had been shifted in. Backward jumps and the zero-offset self-loop catch a design that measures the offset from the argument byte instead of the opcode byte. A load-port write made in the middle of a run is later read back through 0x15, so a design that accepts it would return the wrong local.

// File: rtl/bce_pkg.sv
`timescale 1ns/1ps
package bce_pkg;

    localparam logic [7:0] OP_BIPUSH = 8'h10;
    localparam logic [7:0] OP_LDCW   = 8'h13;
    localparam logic [7:0] OP_ILOAD  = 8'h15;
    localparam logic [7:0] OP_POP    = 8'h57;
    localparam logic [7:0] OP_DUP    = 8'h59;
    localparam logic [7:0] OP_IADD   = 8'h60;
    localparam logic [7:0] OP_IINC   = 8'h84;
    localparam logic [7:0] OP_GOTO   = 8'hA7;
    localparam logic [7:0] OP_IRET   = 8'hAC;

    // decode phase of the byte currently on the code port
    typedef enum logic [2:0] {
        PH_OPC  = 3'd0,
        PH_ARG1 = 3'd1,
        PH_ARG2 = 3'd2,
        PH_DONE = 3'd3,
        PH_TRAP = 3'd4
    } phase_e;

    // operand stack command
    typedef enum logic [1:0] {
        SK_HOLD = 2'd0,
        SK_PUSH = 2'd1,
        SK_POP  = 2'd2,
        SK_FOLD = 2'd3
    } skop_e;

endpackage

// File: rtl/bce_opstack.sv
`timescale 1ns/1ps
module bce_opstack
    import bce_pkg::*;
#(
    parameter int W     = 32,
    parameter int DEPTH = 16,
    parameter int SCW   = $clog2(DEPTH + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  skop_e          op,
    input  logic [W-1:0]   din,
    output logic [W-1:0]   top,
    output logic [W-1:0]   below,
    output logic [SCW-1:0] count
);

    logic [DEPTH-1:0][W-1:0] ent_d, ent_q;
    logic [SCW-1:0]          cnt_d, cnt_q;

    // each lane picks from its upper neighbour (push) or lower neighbour (pop)
    for (genvar i = 0; i < DEPTH; i++) begin : g_lane
        logic [W-1:0] push_v;
        logic [W-1:0] pop_v;
        if (i == 0) begin : g_head
            assign push_v = din;
        end else begin : g_body
            assign push_v = ent_q[i-1];
        end
        if (i == DEPTH - 1) begin : g_tail
            assign pop_v = '0;
        end else begin : g_inner
            assign pop_v = ent_q[i+1];
        end
        assign ent_d[i] = (op == SK_PUSH) ? push_v :
                          (op == SK_POP)  ? pop_v  :
                          (op == SK_FOLD) ? ((i == 0) ? din : pop_v) :
                                            ent_q[i];
    end

    always_comb begin
        cnt_d = cnt_q;
        unique case (op)
            SK_PUSH:         cnt_d = cnt_q + SCW'(1);
            SK_POP, SK_FOLD: cnt_d = cnt_q - SCW'(1);
            default:         cnt_d = cnt_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ent_q <= '0;
            cnt_q <= '0;
        end else begin
            ent_q <= ent_d;
            cnt_q <= cnt_d;
        end
    end

    assign top   = ent_q[0];
    assign below = ent_q[1];
    assign count = cnt_q;

endmodule

// File: rtl/bce_regfile.sv
`timescale 1ns/1ps
module bce_regfile #(
    parameter int W     = 32,
    parameter int DEPTH = 8,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);

    logic [DEPTH-1:0][W-1:0] cells;

    for (genvar i = 0; i < DEPTH; i++) begin : g_cell
        logic [W-1:0] c_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                c_q <= '0;
            end else if (we && (waddr == AW'(i))) begin
                c_q <= wdata;
            end
        end
        assign cells[i] = c_q;
    end

    assign rdata = cells[raddr];

endmodule

// File: rtl/bce_engine.sv
`timescale 1ns/1ps
module bce_engine
    import bce_pkg::*;
#(
    parameter int W          = 32,
    parameter int PCW        = 16,
    parameter int STK_DEPTH  = 16,
    parameter int LOC_DEPTH  = 8,
    parameter int POOL_DEPTH = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           go,
    input  logic           ld_we,
    input  logic           ld_pool,
    input  logic [7:0]     ld_addr,
    input  logic [W-1:0]   ld_data,
    input  logic [7:0]     code_byte,
    output logic [PCW-1:0] pc,
    output logic [W-1:0]   tos,
    output logic           halted,
    output logic           fault,
    output logic [W-1:0]   ret_val
);

    localparam int SCW = $clog2(STK_DEPTH + 1);
    localparam int LAW = $clog2(LOC_DEPTH);
    localparam int PAW = $clog2(POOL_DEPTH);

    typedef struct packed {
        phase_e         ph;
        logic [PCW-1:0] pc;
        logic [PCW-1:0] op_pc;
        logic [7:0]     op;
        logic [7:0]     a1;
        logic [W-1:0]   ret;
    } core_t;

    core_t core_d, core_q;

    function automatic logic [W-1:0] sx8(input logic [7:0] b);
        return {{(W-8){b[7]}}, b};
    endfunction

    // stack interface
    skop_e          sk_op;
    logic [W-1:0]   sk_din;
    logic [W-1:0]   s_top, s_below;
    logic [SCW-1:0] stk_cnt;
    logic           stk_full, stk_empty, stk_two;

    // local and pool interfaces
    logic [7:0]     loc_idx;
    logic [15:0]    pool_idx;
    logic           loc_ok, pool_ok;
    logic [W-1:0]   loc_rd, pool_rd;
    logic           eng_we;
    logic [W-1:0]   eng_wd;
    logic           ld_loc_ok, ld_pool_ok;
    logic           loc_we;
    logic [LAW-1:0] loc_wa;
    logic [W-1:0]   loc_wd;
    logic [31:0]    jmp_ofs;

    assign stk_full  = (stk_cnt == SCW'(STK_DEPTH));
    assign stk_empty = (stk_cnt == '0);
    assign stk_two   = (stk_cnt >= SCW'(2));

    assign loc_idx  = (core_q.ph == PH_ARG1) ? code_byte : core_q.a1;
    assign pool_idx = {core_q.a1, code_byte};
    assign loc_ok   = (int'(loc_idx) < LOC_DEPTH);
    assign pool_ok  = (int'(pool_idx) < POOL_DEPTH);
    assign jmp_ofs  = {{16{core_q.a1[7]}}, core_q.a1, code_byte};

    always_comb begin
        core_d = core_q;
        sk_op  = SK_HOLD;
        sk_din = '0;
        eng_we = 1'b0;
        eng_wd = '0;
        if (go) begin
            unique case (core_q.ph)
                PH_OPC: begin
                    core_d.op    = code_byte;
                    core_d.op_pc = core_q.pc;
                    unique case (code_byte)
                        OP_BIPUSH, OP_LDCW, OP_ILOAD, OP_IINC, OP_GOTO: begin
                            core_d.pc = core_q.pc + PCW'(1);
                            core_d.ph = PH_ARG1;
                        end
                        OP_DUP: begin
                            if (stk_full) begin
                                core_d.ph = PH_TRAP;
                            end else begin
                                sk_op     = SK_PUSH;
                                sk_din    = s_top;
                                core_d.pc = core_q.pc + PCW'(1);
                            end
                        end
                        OP_POP: begin
                            if (stk_empty) begin
                                core_d.ph = PH_TRAP;
                            end else begin
                                sk_op     = SK_POP;
                                core_d.pc = core_q.pc + PCW'(1);
                            end
                        end
                        OP_IADD: begin
                            if (!stk_two) begin
                                core_d.ph = PH_TRAP;
                            end else begin
                                sk_op     = SK_FOLD;
                                sk_din    = s_top + s_below;
                                core_d.pc = core_q.pc + PCW'(1);
                            end
                        end
                        OP_IRET: begin
                            if (stk_empty) begin
                                core_d.ph = PH_TRAP;
                            end else begin
                                core_d.ret = s_top;
                                core_d.ph  = PH_DONE;
                            end
                        end
                        default: core_d.ph = PH_TRAP;
                    endcase
                end
                PH_ARG1: begin
                    core_d.a1 = code_byte;
                    unique case (core_q.op)
                        OP_BIPUSH: begin
                            if (stk_full) begin
                                core_d.ph = PH_TRAP;
                            end else begin
                                sk_op     = SK_PUSH;
                                sk_din    = sx8(code_byte);
                                core_d.pc = core_q.pc + PCW'(1);
                                core_d.ph = PH_OPC;
                            end
                        end
                        OP_ILOAD: begin
                            if (stk_full || !loc_ok) begin
                                core_d.ph = PH_TRAP;
                            end else begin
                                sk_op     = SK_PUSH;
                                sk_din    = loc_rd;
                                core_d.pc = core_q.pc + PCW'(1);
                                core_d.ph = PH_OPC;
                            end
                        end
                        default: begin
                            core_d.pc = core_q.pc + PCW'(1);
                            core_d.ph = PH_ARG2;
                        end
                    endcase
                end
                PH_ARG2: begin
                    unique case (core_q.op)
                        OP_GOTO: begin
                            core_d.pc = core_q.op_pc + jmp_ofs[PCW-1:0];
                            core_d.ph = PH_OPC;
                        end
                        OP_IINC: begin
                            if (!loc_ok) begin
                                core_d.ph = PH_TRAP;
                            end else begin
                                eng_we    = 1'b1;
                                eng_wd    = loc_rd + sx8(code_byte);
                                core_d.pc = core_q.pc + PCW'(1);
                                core_d.ph = PH_OPC;
                            end
                        end
                        OP_LDCW: begin
                            if (stk_full || !pool_ok) begin
                                core_d.ph = PH_TRAP;
                            end else begin
                                sk_op     = SK_PUSH;
                                sk_din    = pool_rd;
                                core_d.pc = core_q.pc + PCW'(1);
                                core_d.ph = PH_OPC;
                            end
                        end
                        default: core_d.ph = PH_TRAP;
                    endcase
                end
                default: core_d = core_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            core_q <= '0;
        end else begin
            core_q <= core_d;
        end
    end

    // load port only acts while the engine is parked
    assign ld_loc_ok  = ld_we && !go && !ld_pool && (int'(ld_addr) < LOC_DEPTH);
    assign ld_pool_ok = ld_we && !go &&  ld_pool && (int'(ld_addr) < POOL_DEPTH);
    assign loc_we     = eng_we || ld_loc_ok;
    assign loc_wa     = eng_we ? loc_idx[LAW-1:0] : ld_addr[LAW-1:0];
    assign loc_wd     = eng_we ? eng_wd : ld_data;

    bce_opstack #(.W(W), .DEPTH(STK_DEPTH), .SCW(SCW)) u_stack (
        .clk   (clk),
        .rst_n (rst_n),
        .op    (sk_op),
        .din   (sk_din),
        .top   (s_top),
        .below (s_below),
        .count (stk_cnt)
    );

    bce_regfile #(.W(W), .DEPTH(LOC_DEPTH), .AW(LAW)) u_locals (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (loc_we),
        .waddr (loc_wa),
        .wdata (loc_wd),
        .raddr (loc_idx[LAW-1:0]),
        .rdata (loc_rd)
    );

    bce_regfile #(.W(W), .DEPTH(POOL_DEPTH), .AW(PAW)) u_pool (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ld_pool_ok),
        .waddr (ld_addr[PAW-1:0]),
        .wdata (ld_data),
        .raddr (pool_idx[PAW-1:0]),
        .rdata (pool_rd)
    );

    assign pc      = core_q.pc;
    assign tos     = s_top;
    assign halted  = (core_q.ph == PH_DONE);
    assign fault   = (core_q.ph == PH_TRAP);
    assign ret_val = core_q.ret;

endmodule

// File: rtl/bce_engine_chk.sv
`timescale 1ns/1ps
module bce_engine_chk #(
    parameter int W         = 32,
    parameter int PCW       = 16,
    parameter int STK_DEPTH = 16,
    parameter int SCW       = $clog2(STK_DEPTH + 1)
) (
    input logic           clk,
    input logic           rst_n,
    input logic           go,
    input logic [PCW-1:0] pc,
    input logic [W-1:0]   tos,
    input logic           halted,
    input logic           fault,
    input logic [W-1:0]   ret_val,
    input logic [SCW-1:0] stk_cnt
);

    p_stop_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(halted && fault));

    p_halt_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted && $stable(ret_val) && $stable(pc) && $stable(tos));

    p_ret_value_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(halted) |-> ret_val == $past(tos));

    p_fault_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> fault && $stable(pc) && $stable(tos) && $stable(stk_cnt));

    p_park_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !go |=> $stable(pc) && $stable(tos) && $stable(stk_cnt));

    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        stk_cnt <= SCW'(STK_DEPTH));

    p_one_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (stk_cnt == $past(stk_cnt)) ||
        (stk_cnt == $past(stk_cnt) + SCW'(1)) ||
        (stk_cnt + SCW'(1) == $past(stk_cnt)));

endmodule

bind bce_engine bce_engine_chk #(
    .W(W), .PCW(PCW), .STK_DEPTH(STK_DEPTH), .SCW($clog2(STK_DEPTH + 1))
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .go      (go),
    .pc      (pc),
    .tos     (tos),
    .halted  (halted),
    .fault   (fault),
    .ret_val (ret_val),
    .stk_cnt (stk_cnt)
);

// File: tb/bce_engine_bench.sv
`timescale 1ns/1ps
module bce_engine_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        go = 1'b0;
    logic        ld_we = 1'b0;
    logic        ld_pool = 1'b0;
    logic [7:0]  ld_addr = '0;
    logic [31:0] ld_data = '0;
    logic [7:0]  code_byte;
    logic [15:0] pc;
    logic [31:0] tos;
    logic        halted, fault;
    logic [31:0] ret_val;

    logic [7:0]  code_mem [256];
    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    assign code_byte = code_mem[pc[7:0]];

    bce_engine u_bce_engine (
        .clk(clk), .rst_n(rst_n), .go(go), .ld_we(ld_we), .ld_pool(ld_pool),
        .ld_addr(ld_addr), .ld_data(ld_data), .code_byte(code_byte),
        .pc(pc), .tos(tos), .halted(halted), .fault(fault), .ret_val(ret_val)
    );

    typedef struct packed {
        logic [95:0] prog;
        logic        flt;
        logic [31:0] ret;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VEC [NV] = '{
        '{96'h10_05_10_FE_57_AC_00_00_00_00_00_00, 1'b0, 32'h0000_0005}, // R2
        '{96'h10_80_AC_00_00_00_00_00_00_00_00_00, 1'b0, 32'hFFFF_FF80}, // R2
        '{96'h10_07_59_60_AC_00_00_00_00_00_00_00, 1'b0, 32'h0000_000E}, // R3
        '{96'h10_03_10_FD_60_AC_00_00_00_00_00_00, 1'b0, 32'h0000_0000}, // R3
        '{96'hA7_00_05_10_01_10_09_AC_00_00_00_00, 1'b0, 32'h0000_0009}, // R4
        '{96'hA7_00_06_10_2A_AC_A7_FF_FD_00_00_00, 1'b0, 32'h0000_002A}, // R4
        '{96'h84_02_FF_15_02_AC_00_00_00_00_00_00, 1'b0, 32'h0000_0101}, // R5
        '{96'h84_07_05_15_07_AC_00_00_00_00_00_00, 1'b0, 32'h0000_010C}, // R5
        '{96'h13_00_03_AC_00_00_00_00_00_00_00_00, 1'b0, 32'h0000_5003}, // R6
        '{96'h13_00_07_10_01_60_AC_00_00_00_00_00, 1'b0, 32'h0000_5008}, // R6
        '{96'h10_01_FF_00_00_00_00_00_00_00_00_00, 1'b1, 32'h0},         // R9
        '{96'h57_00_00_00_00_00_00_00_00_00_00_00, 1'b1, 32'h0},         // R8
        '{96'h10_01_60_00_00_00_00_00_00_00_00_00, 1'b1, 32'h0},         // R8
        '{96'h13_01_00_00_00_00_00_00_00_00_00_00, 1'b1, 32'h0},         // R9
        '{96'h15_08_00_00_00_00_00_00_00_00_00_00, 1'b1, 32'h0},         // R9
        '{96'hAC_00_00_00_00_00_00_00_00_00_00_00, 1'b1, 32'h0}          // R8
    };
    localparam string VTAG [NV] = '{"R2", "R2", "R3", "R3", "R4", "R4", "R5", "R5",
                                    "R6", "R6", "R9", "R8", "R8", "R9", "R9", "R8"};

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        go = 1'b0;
        ld_we = 1'b0;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic load(input logic bank, input logic [7:0] a, input logic [31:0] d);
        ld_pool = bank;
        ld_addr = a;
        ld_data = d;
        ld_we = 1'b1;
        @(negedge clk);
        ld_we = 1'b0;
    endtask

    // locals get 0x100+i, pool entries 0x5000+i
    task automatic load_all();
        for (int i = 0; i < 8; i++) load(1'b0, 8'(i), 32'h100 + i);
        for (int i = 0; i < 8; i++) load(1'b1, 8'(i), 32'h5000 + i);
    endtask

    task automatic clear_code();
        for (int i = 0; i < 256; i++) code_mem[i] = 8'h00;
    endtask

    task automatic wait_stop(input string req);
        int c = 0;
        while (!halted && !fault && c < 400) begin
            @(negedge clk);
            c++;
        end
        check(c < 400, req, 32'(c), 32'd400);
    endtask

    initial begin
        #1_200_000;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", n_chk, 0);
        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        clear_code();

        // R1: reset state
        do_reset();
        check(pc == 16'h0 && tos == 32'h0, "R1", {pc, tos[15:0]}, 32'h0);
        check(!halted && !fault && ret_val == 32'h0, "R1", ret_val, 32'h0);

        // vector table
        for (int k = 0; k < NV; k++) begin
            clear_code();
            for (int b = 0; b < 12; b++) code_mem[b] = VEC[k].prog[95 - 8*b -: 8];
            do_reset();
            load_all();
            go = 1'b1;
            wait_stop(VTAG[k]);
            check(fault == VEC[k].flt && halted == !VEC[k].flt, VTAG[k],
                  {30'b0, halted, fault}, {30'b0, !VEC[k].flt, VEC[k].flt});
            if (!VEC[k].flt) begin
                check(ret_val == VEC[k].ret, VTAG[k], ret_val, VEC[k].ret);
            end else begin
                repeat (4) @(negedge clk);
                check(fault && !halted, VTAG[k], {31'b0, fault}, 32'd1);
            end
            go = 1'b0;
        end

        // R11: one byte per cycle, 10 05 59 AC
        clear_code();
        code_mem[0] = 8'h10; code_mem[1] = 8'h05; code_mem[2] = 8'h59; code_mem[3] = 8'hAC;
        do_reset();
        go = 1'b1;
        @(negedge clk);
        check(pc == 16'd1 && tos == 32'd0, "R11", {16'b0, pc}, 32'd1);
        @(negedge clk);
        check(pc == 16'd2 && tos == 32'd5, "R11", tos, 32'd5);
        @(negedge clk);
        check(pc == 16'd3 && tos == 32'd5 && !halted, "R11", {16'b0, pc}, 32'd3);
        @(negedge clk);
        check(halted && ret_val == 32'd5, "R11", ret_val, 32'd5);

        // R7: halted state holds regardless of go
        go = 1'b0;
        repeat (2) @(negedge clk);
        go = 1'b1;
        repeat (3) @(negedge clk);
        check(halted && ret_val == 32'd5 && pc == 16'd3, "R7", ret_val, 32'd5);
        go = 1'b0;

        // R8: one push past full
        clear_code();
        for (int i = 0; i < 16; i++) begin
            code_mem[2*i] = 8'h10;
            code_mem[2*i+1] = 8'h01;
        end
        code_mem[32] = 8'h10; code_mem[33] = 8'h02; code_mem[34] = 8'hAC;
        do_reset();
        go = 1'b1;
        wait_stop("R8");
        check(fault && !halted, "R8", {31'b0, fault}, 32'd1);
        check(tos == 32'd1, "R8", tos, 32'd1);
        check(pc == 16'd33, "R8", {16'b0, pc}, 32'd33);
        go = 1'b0;

        // R10: load ignored while running, engine parked while go low
        clear_code();
        code_mem[0] = 8'hA7; code_mem[1] = 8'h00; code_mem[2] = 8'h00;
        do_reset();
        load_all();
        ld_pool = 1'b0; ld_addr = 8'h00; ld_data = 32'hDEAD_BEEF; ld_we = 1'b1;
        go = 1'b1;
        repeat (6) @(negedge clk);
        go = 1'b0;
        ld_we = 1'b0;
        check(pc == 16'd0 && !fault, "R10", {16'b0, pc}, 32'd0);
        code_mem[0] = 8'h15; code_mem[1] = 8'h00; code_mem[2] = 8'hAC;
        repeat (4) @(negedge clk);
        check(pc == 16'd0 && tos == 32'd0, "R10", {16'b0, pc}, 32'd0);
        go = 1'b1;
        wait_stop("R10");
        check(halted && ret_val == 32'h100, "R10", ret_val, 32'h100);
        go = 1'b0;

        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule